// File: doc/BRIEF.md
# Configuration Base Address Register Bank

This block keeps the six 32-bit base address registers of one configuration function. Each register is given a kind when the block is built (unused, I/O space or 32-bit memory space), a size and an optional default base. Configuration software writes the registers one byte at a time. Each write leaves the raw byte in place and marks that register as touched. When the access is over, a done strobe starts a commit scan. The scan walks the registers in index order, one per clock. Every touched register is cut down to its size alignment, its low flag bits are forced according to its kind, and its touched mark is cleared.

Each committed I/O or memory register also sends out a one-cycle relocation pulse with its index and the new base address, with the flag bits removed. Downstream address decoders can retarget from that pulse. A busy output is high for the whole scan. While it is high, new writes and new strobes are ignored. A register kind of 24-bit memory, or a size that is not a power of two, stops elaboration.

Top module: `bar_bank`

## Requirements
- R1: After reset, with the default build (BAR0 I/O 16 ports, default 0xC000; BAR1 memory 4 pages, default 0xFEB00000, no read handler; BAR2 and BAR5 unused; BAR3 I/O 256 ports, no default 0x0000FFFF; BAR4 memory 1 page, has a read handler, no default 0xFFFFFFFF), BAR i reads back at offset 0x10+4*i as 0x0000C001, 0xFEB00008, 0, 0x00000001, 0, 0.
- R2: A byte write at offset 0x10+4*i+b (b = 0..3) with the bank idle puts the byte into bits [8b+7:8b] of BAR i. It is readable at once, before any commit. Writes at offsets below 0x10 or at 0x28 and above change nothing. A read of such an offset returns 0.
- R3: Committing an I/O BAR of N ports stores (v & ~(N-1)) with bits [1:0] forced to 01.
- R4: Committing a memory BAR of P pages stores (v & ~(P*4096-1)) with bits [3:0] forced to its reset flags: 0x8 when it has no read handler, otherwise 0x0.
- R5: Committing an unused BAR stores 0 and produces no relocation pulse.
- R6: A done strobe with the bank idle raises busy on the next edge. Busy then stays high for exactly 6 cycles. BAR i is committed at the (i+2)-th edge after the strobe edge, and its relocation pulse shows for one cycle after that edge. The pulse carries index i and a base equal to the stored value with bits [1:0] cleared for I/O or bits [3:0] cleared for memory. Pulses come in ascending index order.
- R7: A BAR whose touched mark is clear is neither changed nor reported during a scan. All marks are clear when the scan ends, so a second strobe with no writes gives no pulse.
- R8: Byte writes and done strobes that arrive while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Byte write strobe |
| cfg_wr_off | input | 8 | Configuration byte offset of the write |
| cfg_wr_byte | input | 8 | Write data byte |
| cfg_wr_done | input | 1 | End of configuration access, starts the commit scan |
| cfg_rd_off | input | 8 | Configuration byte offset to read (dword selected by bits [7:2]) |
| cfg_rd_data | output | 32 | Current dword of the addressed BAR, 0 outside the BAR window |
| scan_busy | output | 1 | Commit scan in progress |
| reloc_valid | output | 1 | One-cycle relocation pulse |
| reloc_idx | output | 3 | Index of the relocated BAR |
| reloc_base | output | 32 | New base address without flag bits |

## Verification
Byte writes show on the read port right after the edge that samples them. Busy rises one edge after the strobe. The commit and the pulse for BAR i appear i+2 edges after the strobe edge, and busy falls after the seventh. The bench steps a behavioural model once per clock with the same inputs it drives. It compares busy, the pulse and its fields, and the read data for a rotating read offset at every falling edge, so each result is checked in exactly the cycle it is due. Writes and strobes sent in the middle of a scan, and a strobe with nothing touched, are checked the same way: the model predicts that nothing moves.

// File: rtl/bar_pkg.sv
package bar_pkg;

   typedef enum logic [1:0] {
      BAR_OFF   = 2'd0,
      BAR_IO    = 2'd1,
      BAR_MEM32 = 2'd2,
      BAR_MEM24 = 2'd3
   } bar_kind_e;

   // Address alignment mask derived from the configured size
   function automatic logic [31:0] addr_mask(input logic [1:0] kind, input logic [31:0] size);
      logic [31:0] m;
      case (kind)
         BAR_IO:    m = ~(size - 32'd1);
         BAR_MEM32: m = ~((size << 12) - 32'd1);
         default:   m = 32'h0;
      endcase
      return m;
   endfunction

   // Width of the flag field in the low bits
   function automatic logic [31:0] flag_mask(input logic [1:0] kind);
      logic [31:0] m;
      case (kind)
         BAR_IO:    m = 32'h3;
         BAR_MEM32: m = 32'hF;
         default:   m = 32'h0;
      endcase
      return m;
   endfunction

   // Forced flag value for each kind
   function automatic logic [31:0] flag_value(input logic [1:0] kind, input bit pref);
      logic [31:0] v;
      case (kind)
         BAR_IO:    v = 32'h1;
         BAR_MEM32: v = pref ? 32'h8 : 32'h0;
         default:   v = 32'h0;
      endcase
      return v;
   endfunction

   function automatic bit no_default(input logic [1:0] kind, input logic [31:0] dflt);
      bit r;
      case (kind)
         BAR_IO:    r = (dflt[15:0] == 16'hFFFF);
         BAR_MEM32: r = (dflt == 32'hFFFF_FFFF);
         default:   r = 1'b1;
      endcase
      return r;
   endfunction

   function automatic logic [31:0] reset_value(input logic [1:0] kind, input logic [31:0] size,
                                               input logic [31:0] dflt, input bit pref);
      logic [31:0] base;
      logic [31:0] d;
      d    = (kind == BAR_IO) ? {16'h0, dflt[15:0]} : dflt;
      base = no_default(kind, dflt) ? 32'h0 : (d & addr_mask(kind, size) & ~flag_mask(kind));
      return base | flag_value(kind, pref);
   endfunction

   function automatic bit is_pow2(input logic [31:0] v);
      return (v != 32'h0) && ((v & (v - 32'd1)) == 32'h0);
   endfunction

endpackage

// File: rtl/bar_slot.sv
module bar_slot
   import bar_pkg::*;
#(
   parameter logic [1:0]  KIND = 2'd0,
   parameter logic [31:0] SIZE = 32'd0,
   parameter logic [31:0] DFLT = 32'h0,
   parameter bit          PREF = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_sel,
   input  logic [1:0]  wr_lane,
   input  logic [7:0]  wr_byte,
   input  logic        commit_en,
   output logic [31:0] val,
   output logic        upd,
   output logic        fire,
   output logic [31:0] new_base
);

   localparam logic [31:0] AMASK = addr_mask(KIND, SIZE);
   localparam logic [31:0] FMASK = flag_mask(KIND);
   localparam logic [31:0] FLAGS = flag_value(KIND, PREF);
   localparam logic [31:0] INIT  = reset_value(KIND, SIZE, DFLT, PREF);

   logic [31:0] commit_val;

   assign commit_val = (val & AMASK & ~FMASK) | FLAGS;
   assign new_base   = commit_val & ~FMASK;
   assign fire       = upd && (KIND != BAR_OFF);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val <= INIT;
         upd <= 1'b0;
      end else if (commit_en) begin
         val <= commit_val;
         upd <= 1'b0;
      end else if (wr_sel) begin
         val[{wr_lane, 3'b000} +: 8] <= wr_byte;
         upd <= 1'b1;
      end
   end

   // R7
   untouched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit_en && !wr_sel) |=> $stable(val));

   // R7
   mark_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_en |=> !upd);

   generate
      if (KIND == BAR_IO) begin : g_io
         // R3
         io_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            commit_en |=> (val[1:0] == 2'b01));
      end else if (KIND == BAR_MEM32) begin : g_mem
         // R4
         mem_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            commit_en |=> (val[3:0] == FLAGS[3:0]));
      end else begin : g_off
         // R5
         unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            commit_en |=> (val == 32'h0));
         // R5
         unused_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !fire);
      end
   endgenerate

endmodule

// File: rtl/bar_scan.sv
module bar_scan #(
   parameter int NUM_BARS = 6,
   localparam int IDXW    = $clog2(NUM_BARS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   output logic            busy,
   output logic [IDXW-1:0] ptr
);

   localparam logic [IDXW-1:0] LAST = IDXW'(NUM_BARS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         ptr  <= '0;
      end else if (busy) begin
         if (ptr == LAST) begin
            busy <= 1'b0;
            ptr  <= '0;
         end else begin
            ptr <= ptr + 1'b1;
         end
      end else if (start) begin
         busy <= 1'b1;
         ptr  <= '0;
      end
   end

   // R6
   scan_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && ptr == '0));

   // R6
   scan_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ptr == LAST) |=> !busy);

   // R6
   scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ptr != LAST) |=> (busy && ptr == $past(ptr) + 1'b1));

endmodule

// File: rtl/bar_bank.sv
module bar_bank
   import bar_pkg::*;
#(
   parameter int                      NUM_BARS = 6,
   parameter int                      BASE_OFF = 16,
   // kinds, BAR5..BAR0 : 0 unused, 1 I/O, 2 memory 32-bit, 3 memory 24-bit (rejected)
   parameter logic [NUM_BARS*2-1:0]   BAR_KIND = {2'd0, 2'd2, 2'd1, 2'd0, 2'd2, 2'd1},
   // sizes: ports for I/O, 4 KB pages for memory
   parameter logic [NUM_BARS*32-1:0]  BAR_SIZE = {32'd0, 32'd1, 32'd256, 32'd0, 32'd4, 32'd16},
   parameter logic [NUM_BARS*32-1:0]  BAR_DFLT = {32'h0, 32'hFFFF_FFFF, 32'h0000_FFFF,
                                                 32'h0, 32'hFEB0_0000, 32'h0000_C000},
   // memory BAR without a read handler: prefetchable flag
   parameter logic [NUM_BARS-1:0]     BAR_PREF = 6'b000010,
   localparam int                     IDXW     = $clog2(NUM_BARS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_wr_en,
   input  logic [7:0]      cfg_wr_off,
   input  logic [7:0]      cfg_wr_byte,
   input  logic            cfg_wr_done,
   input  logic [7:0]      cfg_rd_off,
   output logic [31:0]     cfg_rd_data,
   output logic            scan_busy,
   output logic            reloc_valid,
   output logic [IDXW-1:0] reloc_idx,
   output logic [31:0]     reloc_base
);

   localparam int WIN_END = BASE_OFF + 4 * NUM_BARS;

   // elaboration checks
   if (NUM_BARS < 1)
      $error("bar_bank: NUM_BARS must be at least one");
   if (WIN_END > 256)
      $error("bar_bank: BAR window exceeds the configuration space");
   if ((BASE_OFF % 4) != 0)
      $error("bar_bank: BASE_OFF must be dword aligned");

   logic [31:0]   slot_val  [NUM_BARS];
   logic [31:0]   slot_base [NUM_BARS];
   logic [NUM_BARS-1:0] slot_upd;
   logic [NUM_BARS-1:0] slot_fire;
   logic [IDXW-1:0] ptr;
   logic            wr_hit;
   logic            rd_hit;
   logic [IDXW+1:0] wrel;
   logic [IDXW+1:0] rrel;
   logic [IDXW-1:0] widx;
   logic [IDXW-1:0] ridx;

   assign wr_hit = cfg_wr_en && !scan_busy
                   && (int'(cfg_wr_off) >= BASE_OFF) && (int'(cfg_wr_off) < WIN_END);
   assign rd_hit = (int'(cfg_rd_off) >= BASE_OFF) && (int'(cfg_rd_off) < WIN_END);
   assign wrel   = (IDXW+2)'(cfg_wr_off - 8'(BASE_OFF));
   assign rrel   = (IDXW+2)'(cfg_rd_off - 8'(BASE_OFF));
   assign widx   = wrel[IDXW+1:2];
   assign ridx   = rrel[IDXW+1:2];

   bar_scan #(.NUM_BARS(NUM_BARS)) u_scan (
      .clk   (clk),
      .rst_n (rst_n),
      .start (cfg_wr_done),
      .busy  (scan_busy),
      .ptr   (ptr)
   );

   for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
      localparam logic [1:0]  K = BAR_KIND[2*i +: 2];
      localparam logic [31:0] S = BAR_SIZE[32*i +: 32];

      if (K == BAR_MEM24) begin : g_bad24
         $error("bar_bank: 24-bit memory BARs are not supported");
      end
      if (K == BAR_IO && !is_pow2(S)) begin : g_bad_io
         $error("bar_bank: I/O BAR size must be a power of two");
      end
      if (K == BAR_MEM32 && (!is_pow2(S) || S > 32'h0010_0000)) begin : g_bad_mem
         $error("bar_bank: memory BAR page count must be a power of two within 4 GB");
      end

      bar_slot #(
         .KIND (K),
         .SIZE (S),
         .DFLT (BAR_DFLT[32*i +: 32]),
         .PREF (BAR_PREF[i])
      ) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_sel    (wr_hit && (widx == IDXW'(i))),
         .wr_lane   (wrel[1:0]),
         .wr_byte   (cfg_wr_byte),
         .commit_en (scan_busy && (ptr == IDXW'(i))),
         .val       (slot_val[i]),
         .upd       (slot_upd[i]),
         .fire      (slot_fire[i]),
         .new_base  (slot_base[i])
      );
   end

   assign cfg_rd_data = rd_hit ? slot_val[ridx] : 32'h0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reloc_valid <= 1'b0;
         reloc_idx   <= '0;
         reloc_base  <= 32'h0;
      end else begin
         reloc_valid <= scan_busy && slot_fire[ptr];
         reloc_idx   <= ptr;
         reloc_base  <= slot_base[ptr];
      end
   end

   // R6
   reloc_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reloc_valid |-> $past(scan_busy));

   // R6
   reloc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reloc_valid && $past(reloc_valid)) |-> (reloc_idx > $past(reloc_idx)));

   // R7
   marks_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scan_busy) |-> (slot_upd == '0));

   // R8
   busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_busy && cfg_wr_en) |=> !$past(wr_hit));

endmodule

// File: tb/bar_bank_test.sv
module bar_bank_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [7:0]  cfg_wr_off = 8'h0;
   logic [7:0]  cfg_wr_byte = 8'h0;
   logic        cfg_wr_done = 1'b0;
   logic [7:0]  cfg_rd_off = 8'h10;
   logic [31:0] cfg_rd_data;
   logic        scan_busy;
   logic        reloc_valid;
   logic [2:0]  reloc_idx;
   logic [31:0] reloc_base;

   always #2 clk = ~clk;   // 250 MHz

   bar_bank uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_off(cfg_wr_off),
      .cfg_wr_byte(cfg_wr_byte), .cfg_wr_done(cfg_wr_done), .cfg_rd_off(cfg_rd_off),
      .cfg_rd_data(cfg_rd_data), .scan_busy(scan_busy), .reloc_valid(reloc_valid),
      .reloc_idx(reloc_idx), .reloc_base(reloc_base)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;
   string tag = "R1";
   int rd_rot = 0;

   // reference model state
   int          m_kind [6] = '{1, 2, 0, 1, 2, 0};
   int          m_size [6] = '{16, 4, 0, 256, 1, 0};
   logic [31:0] m_flag [6] = '{32'h1, 32'h8, 32'h0, 32'h1, 32'h0, 32'h0};
   logic [31:0] m_val  [6];
   bit          m_upd  [6];
   bit          m_busy;
   int          m_ptr;
   bit          m_rv;
   int          m_ridx;
   logic [31:0] m_rbase;

   function automatic logic [31:0] fmask(int k);
      return (k == 1) ? 32'h3 : (k == 2) ? 32'hF : 32'h0;
   endfunction

   function automatic logic [31:0] commit_of(int i, logic [31:0] v);
      if (m_kind[i] == 1)
         return (v & ~(32'(m_size[i]) - 32'd1) & ~32'h3) | 32'h1;
      else if (m_kind[i] == 2)
         return (v & ~((32'(m_size[i]) * 32'd4096) - 32'd1) & ~32'hF) | m_flag[i];
      return 32'h0;
   endfunction

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic compare_all();
      check("R6", "busy", 32'(scan_busy), 32'(m_busy));
      check("R6", "reloc_valid", 32'(reloc_valid), 32'(m_rv));
      if (m_rv) begin
         check("R6", "reloc_idx", 32'(reloc_idx), 32'(m_ridx));
         check((m_kind[m_ridx] == 1) ? "R3" : "R4", "reloc_base", reloc_base, m_rbase);
      end
      begin
         int r;
         r = (int'(cfg_rd_off) - 16) / 4;
         check(tag, $sformatf("rd bar%0d", r), cfg_rd_data, m_val[r]);
      end
   endtask

   task automatic model_step(bit we, logic [7:0] off, logic [7:0] d, bit dn);
      m_rv = 0;
      if (m_busy) begin
         int i;
         i = m_ptr;
         if (m_upd[i]) begin
            m_val[i] = commit_of(i, m_val[i]);
            if (m_kind[i] != 0) begin
               m_rv = 1;
               m_ridx = i;
               m_rbase = m_val[i] & ~fmask(m_kind[i]);
            end
         end
         m_upd[i] = 0;
         if (i == 5) m_busy = 0;
         else m_ptr = i + 1;
      end else begin
         if (we && off >= 8'h10 && off < 8'h28) begin
            int b;
            int l;
            b = (int'(off) - 16) / 4;
            l = int'(off) % 4;
            m_val[b][l*8 +: 8] = d;
            m_upd[b] = 1;
         end
         if (dn) begin
            m_busy = 1;
            m_ptr = 0;
         end
      end
   endtask

   task automatic tick(bit we, logic [7:0] off, logic [7:0] d, bit dn);
      @(negedge clk);
      compare_all();
      cfg_wr_en   = we;
      cfg_wr_off  = off;
      cfg_wr_byte = d;
      cfg_wr_done = dn;
      cfg_rd_off  = 8'(16 + 4 * rd_rot);
      rd_rot      = (rd_rot + 1) % 6;
      model_step(we, off, d, dn);
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) tick(0, 8'h0, 8'h0, 0);
   endtask

   task automatic put_word(int bar, logic [31:0] v);
      for (int b = 0; b < 4; b++) tick(1, 8'(16 + 4 * bar + b), v[b*8 +: 8], 0);
   endtask

   initial begin
      m_val = '{32'h0000C001, 32'hFEB00008, 32'h0, 32'h1, 32'h0, 32'h0};
      m_upd = '{0, 0, 0, 0, 0, 0};
      m_busy = 0; m_ptr = 0; m_rv = 0; m_ridx = 0; m_rbase = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values of every BAR
      tag = "R1";
      idle(8);

      // R2: raw byte writes, out-of-window writes ignored
      tag = "R2";
      put_word(0, 32'h12345678);
      tick(1, 8'h0C, 8'hAA, 0);
      tick(1, 8'h28, 8'hBB, 0);
      idle(7);

      // R3/R4/R5: commit a mix of kinds; R8: write and strobe while busy
      tag = "R4";
      put_word(1, 32'hAABBCCDD);
      put_word(2, 32'hFFFFFFFF);
      put_word(4, 32'h12345677);
      tick(0, 8'h0, 8'h0, 1);
      tag = "R8";
      tick(1, 8'h1C, 8'h55, 0);
      tick(0, 8'h0, 8'h0, 1);
      tick(1, 8'h1D, 8'h66, 1);
      idle(10);

      // R7: strobe with nothing touched
      tag = "R7";
      tick(0, 8'h0, 8'h0, 1);
      idle(10);

      // R3: partial I/O writes, full-ones I/O write; R5: unused BAR
      tag = "R3";
      tick(1, 8'h1C, 8'h34, 0);
      tick(1, 8'h1D, 8'hE2, 0);
      put_word(0, 32'hFFFFFFFF);
      tag = "R5";
      put_word(5, 32'hDEADBEEF);
      tick(0, 8'h0, 8'h0, 1);
      idle(10);

      // R4: prefetch flag forced back when written low bits are cleared
      tag = "R4";
      put_word(1, 32'h00000000);
      put_word(4, 32'hFFFFFFFF);
      tick(1, 8'h10, 8'h00, 1);
      idle(10);

      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule